// File: doc/BRIEF.md
# Dual Crystal Oscillator Fault Monitor

This block supervises two crystal oscillator clocks, one slow and one fast, from a faster reference clock. Each oscillator clock passes through a two-flop synchronizer and a rising-edge detector. A per-channel gap counter then measures the number of reference cycles between edges. If no edge arrives within a timeout, the oscillator counts as stopped and an internal fault is raised. The fault is removed only after a run of in-window edges, and any stop or out-of-window edge restarts that run.

Software sees three flags. Each oscillator has a sticky fault flag that can be cleared by a strobe. There is also a combined flag, which is already set when reset is released and which drives an interrupt request whenever it is set and the interrupt enable is high. The fast oscillator is not supervised in the deepest low-power modes. The slow one is supervised in every mode. The reference clock must run well above twice the frequency of either oscillator.

Top module: `osc_fault_mon`

## Requirements
- R1: While a channel is active, its internal fault asserts when the gap counter reaches that channel's TIMEOUT reference cycles without a synchronized rising edge. This is seen as the channel flag going to 1. A channel is active when its osc-on and detect-enable inputs are 1, and for the fast channel also when deep_lpm_i is 0.
- R2: With the startup counter enabled, a fault clears only after STARTUP_CNT consecutive valid edges. An edge is valid when the gap counter at that edge lies in [MIN_GAP, MAX_GAP]. A stop, or an edge outside the window, resets the count to zero.
- R3: With the startup-count enable at 0, a fault clears on the first valid edge.
- R4: A channel flag is set by its fault and holds at 1 after the fault is gone, until a clear strobe arrives while no fault is present.
- R5: A clear strobe has no effect while the fault persists. If a clear and a fault both appear in the same cycle, setting the flag wins.
- R6: The combined flag reads 1 during and after reset. It is set by any channel fault, and its clear strobe is ignored while any fault exists.
- R7: irq_o is 1 exactly when the combined flag and irq_en_i are both 1. Changing irq_en_i never alters any flag.
- R8: While deep_lpm_i is 1, a stopped fast oscillator sets no flag, while a stopped slow oscillator still sets its flag.
- R9: An inactive channel (osc switched off, or detection disabled) never sets its flag. When the channel becomes active again, it reports a fault at once and must requalify as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lf_clk_i | input | 1 | Slow oscillator clock |
| hf_clk_i | input | 1 | Fast oscillator clock |
| lf_on_i | input | 1 | Slow oscillator switched on |
| hf_on_i | input | 1 | Fast oscillator switched on |
| lf_det_en_i | input | 1 | Slow fault detection enable |
| hf_det_en_i | input | 1 | Fast fault detection enable |
| lf_stcnt_en_i | input | 1 | Slow startup counter enable |
| hf_stcnt_en_i | input | 1 | Fast startup counter enable |
| deep_lpm_i | input | 1 | Deepest low-power modes, fast detection off |
| lf_flag_clr_i | input | 1 | Clear strobe for slow flag |
| hf_flag_clr_i | input | 1 | Clear strobe for fast flag |
| comb_flag_clr_i | input | 1 | Clear strobe for combined flag |
| irq_en_i | input | 1 | Interrupt enable |
| lf_flag_o | output | 1 | Slow oscillator fault flag |
| hf_flag_o | output | 1 | Fast oscillator fault flag |
| comb_flag_o | output | 1 | Combined oscillator fault flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with STARTUP_CNT of 8 in place of 1024. It sets a slow window of 7 to 12 reference cycles with a 24-cycle timeout, and a fast window of 2 to 5 with a 10-cycle timeout. With these values a full requalification takes about a hundred reference cycles. This makes it practical to tell apart an interrupted count, a completed count and a bypassed count. It also lets a burst of short periods visibly restart the count part way through.

// File: rtl/osc_fault_pkg.sv
package osc_fault_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_LF  = 0;
  localparam int unsigned CH_HF  = 1;
endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  output logic rise_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], osc_i};
  end

  assign rise_o = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/osc_qual.sv
module osc_qual #(
  parameter int unsigned MIN_GAP     = 100,
  parameter int unsigned MAX_GAP     = 400,
  parameter int unsigned TIMEOUT     = 1000,
  parameter int unsigned STARTUP_CNT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic active_i,
  input  logic stcnt_en_i,
  output logic fault_o
);
  localparam int unsigned GAP_W = $clog2(TIMEOUT + 1);
  localparam int unsigned ST_W  = $clog2(STARTUP_CNT + 1);
  localparam logic [GAP_W-1:0] GAP_MAX_V = GAP_W'(TIMEOUT);
  localparam logic [ST_W-1:0]  ST_LAST   = ST_W'(STARTUP_CNT - 1);

  logic [GAP_W-1:0] gap_q;
  logic [ST_W-1:0]  st_q;
  logic             fault_q;
  logic             stopped, in_win, bad_evt;

  assign stopped = (gap_q == GAP_MAX_V);
  assign in_win  = rise_i && (gap_q >= GAP_W'(MIN_GAP)) && (gap_q <= GAP_W'(MAX_GAP));
  assign bad_evt = stopped || (rise_i && !in_win);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gap_q <= '0;
    else if (rise_i)  gap_q <= '0;
    else if (!stopped) gap_q <= gap_q + 1'b1;
  end

  // held faulty while inactive: reactivation forces requalification
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b1;
      st_q    <= '0;
    end else if (!active_i || bad_evt) begin
      fault_q <= 1'b1;
      st_q    <= '0;
    end else if (fault_q && in_win) begin
      if (!stcnt_en_i || st_q == ST_LAST) begin
        fault_q <= 1'b0;
        st_q    <= '0;
      end else begin
        st_q <= st_q + 1'b1;
      end
    end
  end

  assign fault_o = fault_q & active_i;
endmodule

// File: rtl/osc_sticky_flag.sv
module osc_sticky_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= RST_VAL;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/osc_fault_mon.sv
module osc_fault_mon
  import osc_fault_pkg::*;
#(
  parameter int unsigned LF_MIN_GAP  = 100,
  parameter int unsigned LF_MAX_GAP  = 400,
  parameter int unsigned LF_TIMEOUT  = 1000,
  parameter int unsigned HF_MIN_GAP  = 1,
  parameter int unsigned HF_MAX_GAP  = 6,
  parameter int unsigned HF_TIMEOUT  = 16,
  parameter int unsigned STARTUP_CNT = 1024
) (
  input  logic clk_ref_i,
  input  logic rst_ni,
  input  logic lf_clk_i,
  input  logic hf_clk_i,
  input  logic lf_on_i,
  input  logic hf_on_i,
  input  logic lf_det_en_i,
  input  logic hf_det_en_i,
  input  logic lf_stcnt_en_i,
  input  logic hf_stcnt_en_i,
  input  logic deep_lpm_i,
  input  logic lf_flag_clr_i,
  input  logic hf_flag_clr_i,
  input  logic comb_flag_clr_i,
  input  logic irq_en_i,
  output logic lf_flag_o,
  output logic hf_flag_o,
  output logic comb_flag_o,
  output logic irq_o
);
  logic [NUM_CH-1:0] osc_clk, active, stcnt_en, clr, rise, fault, flag;

  assign osc_clk  = {hf_clk_i, lf_clk_i};
  assign active   = {hf_on_i & hf_det_en_i & ~deep_lpm_i, lf_on_i & lf_det_en_i};
  assign stcnt_en = {hf_stcnt_en_i, lf_stcnt_en_i};
  assign clr      = {hf_flag_clr_i, lf_flag_clr_i};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam bit IS_LF = (i == CH_LF);

    osc_edge_sync u_sync (
      .clk_i  (clk_ref_i),
      .rst_ni (rst_ni),
      .osc_i  (osc_clk[i]),
      .rise_o (rise[i])
    );

    osc_qual #(
      .MIN_GAP     (IS_LF ? LF_MIN_GAP : HF_MIN_GAP),
      .MAX_GAP     (IS_LF ? LF_MAX_GAP : HF_MAX_GAP),
      .TIMEOUT     (IS_LF ? LF_TIMEOUT : HF_TIMEOUT),
      .STARTUP_CNT (STARTUP_CNT)
    ) u_qual (
      .clk_i      (clk_ref_i),
      .rst_ni     (rst_ni),
      .rise_i     (rise[i]),
      .active_i   (active[i]),
      .stcnt_en_i (stcnt_en[i]),
      .fault_o    (fault[i])
    );

    osc_sticky_flag #(.RST_VAL(1'b0)) u_flag (
      .clk_i  (clk_ref_i),
      .rst_ni (rst_ni),
      .set_i  (fault[i]),
      .clr_i  (clr[i]),
      .flag_o (flag[i])
    );
  end

  osc_sticky_flag #(.RST_VAL(1'b1)) u_comb (
    .clk_i  (clk_ref_i),
    .rst_ni (rst_ni),
    .set_i  (|fault),
    .clr_i  (comb_flag_clr_i),
    .flag_o (comb_flag_o)
  );

  assign lf_flag_o = flag[CH_LF];
  assign hf_flag_o = flag[CH_HF];
  assign irq_o     = comb_flag_o & irq_en_i;
endmodule

// File: rtl/osc_fault_mon_chk.sv
module osc_fault_mon_chk (
  input logic clk_ref_i,
  input logic rst_ni,
  input logic lf_on_i,
  input logic hf_on_i,
  input logic deep_lpm_i,
  input logic lf_flag_clr_i,
  input logic hf_flag_clr_i,
  input logic comb_flag_clr_i,
  input logic lf_flag_o,
  input logic hf_flag_o,
  input logic comb_flag_o
);
  AST_LF_FLAG_STICKY: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (lf_flag_o && !lf_flag_clr_i) |=> lf_flag_o); // R4
  AST_HF_FLAG_STICKY: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (hf_flag_o && !hf_flag_clr_i) |=> hf_flag_o); // R4
  AST_COMB_HOLD: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (comb_flag_o && !comb_flag_clr_i) |=> comb_flag_o); // R6
  AST_COMB_ON_LF_SET: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    $rose(lf_flag_o) |-> comb_flag_o); // R6
  AST_COMB_ON_HF_SET: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    $rose(hf_flag_o) |-> comb_flag_o); // R6
  AST_HF_QUIET_LPM: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (deep_lpm_i && !hf_flag_o) |=> !hf_flag_o); // R8
  AST_LF_OFF_NO_SET: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (!lf_on_i && !lf_flag_o) |=> !lf_flag_o); // R9
  AST_HF_OFF_NO_SET: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (!hf_on_i && !hf_flag_o) |=> !hf_flag_o); // R9
endmodule

bind osc_fault_mon osc_fault_mon_chk u_chk (.*);

// File: tb/osc_fault_mon_test.sv
`timescale 1ns/1ps
module osc_fault_mon_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lf_clk = 1'b0, hf_clk = 1'b0;
  logic lf_on = 1'b1, hf_on = 1'b1, lf_det = 1'b1, hf_det = 1'b1;
  logic lf_st = 1'b1, hf_st = 1'b1, deep = 1'b0;
  logic lf_clr = 1'b0, hf_clr = 1'b0, comb_clr = 1'b0, irq_en = 1'b0;
  logic lf_flag, hf_flag, comb_flag, irq;
  int   n_chk = 0, n_fail = 0;
  int   lf_half = 20, hf_half = 8;
  bit   lf_run = 1'b1, hf_run = 1'b1, done = 1'b0;

  always #2 clk = ~clk;
  initial forever begin #(lf_half); if (lf_run) lf_clk = ~lf_clk; end
  initial forever begin #(hf_half); if (hf_run) hf_clk = ~hf_clk; end

  osc_fault_mon #(
    .LF_MIN_GAP(7), .LF_MAX_GAP(12), .LF_TIMEOUT(24),
    .HF_MIN_GAP(2), .HF_MAX_GAP(5),  .HF_TIMEOUT(10),
    .STARTUP_CNT(8)
  ) uut (
    .clk_ref_i(clk), .rst_ni(rst_n), .lf_clk_i(lf_clk), .hf_clk_i(hf_clk),
    .lf_on_i(lf_on), .hf_on_i(hf_on), .lf_det_en_i(lf_det), .hf_det_en_i(hf_det),
    .lf_stcnt_en_i(lf_st), .hf_stcnt_en_i(hf_st), .deep_lpm_i(deep),
    .lf_flag_clr_i(lf_clr), .hf_flag_clr_i(hf_clr), .comb_flag_clr_i(comb_clr),
    .irq_en_i(irq_en), .lf_flag_o(lf_flag), .hf_flag_o(hf_flag),
    .comb_flag_o(comb_flag), .irq_o(irq)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: lf_clr = 1'b1;
      1: hf_clr = 1'b1;
      default: comb_clr = 1'b1;
    endcase
    @(negedge clk);
    lf_clr = 1'b0; hf_clr = 1'b0; comb_clr = 1'b0;
  endtask

  task automatic t_reset;
    wait_cyc(3);
    check(comb_flag, 1'b1, "R6", "combined flag in reset");
    check(lf_flag, 1'b0, "R4", "lf flag in reset");
    check(irq, 1'b0, "R7", "irq in reset");
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(300);
    check(lf_flag, 1'b1, "R4", "lf flag after startup fault");
    check(hf_flag, 1'b1, "R4", "hf flag after startup fault");
    pulse(0); pulse(1);
    check(lf_flag, 1'b0, "R4", "lf flag cleared after qualify");
    check(hf_flag, 1'b0, "R4", "hf flag cleared after qualify");
    check(comb_flag, 1'b1, "R6", "combined still latched");
    pulse(2);
    check(comb_flag, 1'b0, "R6", "combined cleared, no fault");
  endtask

  task automatic t_startup_count;
    lf_run = 1'b0; wait_cyc(40);
    check(lf_flag, 1'b1, "R1", "lf stop raises flag");
    pulse(2);
    check(comb_flag, 1'b1, "R6", "combined clear ignored during fault");
    lf_run = 1'b1; wait_cyc(50);
    pulse(0);
    check(lf_flag, 1'b1, "R2", "lf flag held before count done");
    wait_cyc(150); pulse(0);
    check(lf_flag, 1'b0, "R2", "lf flag clears after count done");
    pulse(2);
  endtask

  task automatic t_restart;
    lf_run = 1'b0; wait_cyc(40);
    lf_run = 1'b1; wait_cyc(80);
    lf_half = 8; #40; lf_half = 20;
    wait_cyc(50); pulse(0);
    check(lf_flag, 1'b1, "R2", "short periods restart count");
    wait_cyc(150); pulse(0);
    check(lf_flag, 1'b0, "R2", "clears after restarted count");
  endtask

  task automatic t_no_stcnt;
    lf_st = 1'b0;
    lf_run = 1'b0; wait_cyc(40);
    lf_run = 1'b1; wait_cyc(35);
    pulse(0);
    check(lf_flag, 1'b0, "R3", "bypassed count clears on first valid edge");
    lf_st = 1'b1;
  endtask

  task automatic t_inactive;
    lf_det = 1'b0;
    lf_run = 1'b0; wait_cyc(40); pulse(0);
    check(lf_flag, 1'b0, "R9", "detect disabled sets no flag");
    lf_run = 1'b1; wait_cyc(30);
    @(negedge clk); lf_det = 1'b1; lf_clr = 1'b1;
    @(negedge clk); lf_clr = 1'b0;
    check(lf_flag, 1'b1, "R5", "set wins over same-cycle clear");
    pulse(0);
    check(lf_flag, 1'b1, "R5", "clear ignored while fault persists");
    wait_cyc(150); pulse(0);
    check(lf_flag, 1'b0, "R9", "requalified after re-enable");
    lf_on = 1'b0;
    lf_run = 1'b0; wait_cyc(40); pulse(0);
    check(lf_flag, 1'b0, "R9", "osc off sets no flag");
    lf_run = 1'b1; lf_on = 1'b1; wait_cyc(150); pulse(0);
    pulse(2);
  endtask

  task automatic t_deep_lpm;
    deep = 1'b1;
    hf_run = 1'b0; lf_run = 1'b0; wait_cyc(40);
    pulse(1);
    check(hf_flag, 1'b0, "R8", "hf stop ignored in deep lpm");
    check(lf_flag, 1'b1, "R8", "lf stop still flagged in deep lpm");
    hf_run = 1'b1; lf_run = 1'b1; wait_cyc(20);
    @(negedge clk); deep = 1'b0;
    wait_cyc(2);
    check(hf_flag, 1'b1, "R9", "hf faulted on leaving deep lpm");
    wait_cyc(150); pulse(0); pulse(1);
    check(hf_flag, 1'b0, "R8", "hf requalified");
    check(lf_flag, 1'b0, "R8", "lf requalified");
  endtask

  task automatic t_irq;
    @(negedge clk); irq_en = 1'b1;
    wait_cyc(1);
    check(irq, 1'b1, "R7", "irq with flag and enable");
    pulse(2);
    check(comb_flag, 1'b0, "R6", "combined clears without fault");
    check(irq, 1'b0, "R7", "irq drops with flag");
    hf_run = 1'b0; wait_cyc(30);
    check(irq, 1'b1, "R7", "irq on hf fault");
    @(negedge clk); irq_en = 1'b0;
    wait_cyc(1);
    check(irq, 1'b0, "R7", "irq masked");
    check(comb_flag, 1'b1, "R7", "mask keeps combined flag");
    hf_run = 1'b1; wait_cyc(150); pulse(1); pulse(2);
    check(comb_flag, 1'b0, "R6", "combined clears at end");
  endtask

  initial begin
    t_reset();
    t_startup_count();
    t_restart();
    t_no_stcnt();
    t_inactive();
    t_deep_lpm();
    t_irq();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule